// File: doc/BRIEF.md
# Byte-Serial Load/Store Unit for a Narrow External Data Memory

This unit links a 32-bit internal datapath to an external data memory that is only one byte wide. It splits each transfer into a series of single-byte accesses in little-endian order. It drives the memory address, the write byte and three active-low strobes, and for reads it collects the returned bytes into one word. A request has an address, a size, a direction, write data and a mode bit. The unit takes a request only when the mode bit is set and no transfer is in progress.

Each byte access holds its address and strobes for a fixed number of cycles, set by a parameter. Read data is captured on the last of those cycles. While a transfer runs, `busy` stays high. One cycle after the final byte, `done` pulses and the finished read word appears on `rdata`. A new request can be accepted in that same `done` cycle.

Top module: `byte_lsu_top`

## Requirements
- R1: During reset and just after it, `busy` and `done` are 0. `mem_cen`, `mem_wen` and `mem_oen` are 1. `mem_a`, `mem_d` and `rdata` are 0.
- R2: A request with `req_mode` = 0 is ignored. `busy` stays low and the memory strobes stay idle.
- R3: `req_size` sets the number of byte accesses: 0 gives one byte, 1 gives a halfword (two bytes), and 2 or 3 give a word (four bytes).
- R4: Byte k of a transfer uses address base+k. On a write, `mem_d` carries bits [8k+7:8k] of the write word. `mem_d` is 0 whenever no write access is active.
- R5: Strobe encodings, all active low. A read access drives cen=0, oen=0, wen=1. A write access drives cen=0, wen=0, oen=1. When no access is active, all three strobes are 1.
- R6: Each byte access holds the same address for exactly WAIT_CYC consecutive cycles, with no gap between accesses. Read data is sampled on the last of those cycles.
- R7: `busy` is high from the cycle after acceptance through the last access cycle. `done` is then high for exactly one cycle, and `busy` is low in that cycle.
- R8: When a read finishes, `rdata` holds byte k in bits [8k+7:8k], and the bytes that were not fetched are 0. When a write finishes, `rdata` becomes 0. `rdata` changes only in the `done` cycle.
- R9: A request that arrives while `busy` is high has no effect on the transfer in progress.
- R10: Byte addresses wrap modulo 1024, so the byte after address 1023 is address 0.
- R11: A request that is present in the `done` cycle is accepted, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_mode | input | 1 | Mode bit from the instruction; 1 enables memory access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 10 | Base byte address |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word |
| mem_a | output | 10 | External memory address |
| mem_d | output | 8 | Byte to external memory |
| mem_q | input | 8 | Byte from external memory |
| mem_cen | output | 1 | Chip enable, active low |
| mem_wen | output | 1 | Write enable, active low |
| mem_oen | output | 1 | Output enable, active low |

## Verification
The bench builds the unit with WAIT_CYC = 3 rather than the default of 2. This exercises the middle cycle of an access as well as its first and last, so the checks show that the address stays fixed and that read data is taken only on the final wait cycle. The address width stays at 10 bits, so transfers that start at 1022 and 1023 cross the wrap point. Holding `req_valid` high across transfers reaches both the ignored-while-busy case and the acceptance in the `done` cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic {
    LS_IDLE = 1'b0,
    LS_XFER = 1'b1
  } lsu_state_e;

  // size code to (byte count - 1); codes 2 and 3 both select a full word
  function automatic logic [1:0] size_to_last(input logic [1:0] sz);
    logic [1:0] r;
    case (sz)
      2'd0:    r = 2'd0;
      2'd1:    r = 2'd1;
      default: r = 2'd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int WAIT_CYC = 2,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_last,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             last_wait,
  output logic             finish,
  output logic             done
);

  localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAIT_CYC - 1);

  lsu_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d;
  logic             done_q, done_d;
  logic             last_byte;
  logic             seq_en;

  assign active    = (st_q == LS_XFER);
  assign last_wait = (wcnt_q == CNT_MAX);
  assign last_byte = (idx_q == last_q);
  assign finish    = active && last_wait && last_byte;
  assign idx       = idx_q;
  assign done      = done_q;
  assign seq_en    = active || start;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    last_d = last_q;
    wcnt_d = wcnt_q;
    done_d = finish;
    case (st_q)
      LS_IDLE: begin
        if (start) begin
          st_d   = LS_XFER;
          idx_d  = '0;
          wcnt_d = '0;
          last_d = start_last;
        end
      end
      LS_XFER: begin
        if (last_wait) begin
          wcnt_d = '0;
          if (last_byte) begin
            st_d  = LS_IDLE;
            idx_d = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end else begin
          wcnt_d = wcnt_q + CNT_W'(1);
        end
      end
      default: st_d = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      wcnt_q <= '0;
    end else if (seq_en) begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      wcnt_q <= wcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(last_wait)) |-> (idx == $past(idx))); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(last_wait)) |-> (idx == $past(idx) + IDX_W'(1))); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active); // R7

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              active,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] mem_a
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic              base_en;

  assign base_en = start;
  assign base_d  = start_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  // sum truncated to ADDR_W bits: wraps at the top of the space
  assign mem_a = active ? (base_q + ADDR_W'(idx)) : '0;

endmodule

// File: rtl/lsu_byte_path.sv
module lsu_byte_path #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              active,
  input  logic [IDX_W-1:0]  idx,
  input  logic              last_wait,
  input  logic              finish,
  input  logic [BYTE_W-1:0] mem_q,
  output logic              wr,
  output logic [BYTE_W-1:0] mem_d,
  output logic [DATA_W-1:0] rdata
);

  localparam int NLANE = DATA_W / BYTE_W;

  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic [DATA_W-1:0] asm_q, asm_d;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [BYTE_W-1:0] wlane [NLANE];
  logic [NLANE-1:0]  hit;
  logic              capture;
  logic              asm_en;

  assign capture = active && last_wait && !wr_q;
  assign asm_en  = start || capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (start) begin
      wdata_q <= start_wdata;
      wr_q    <= start_wr;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign wlane[g] = wdata_q[g*BYTE_W +: BYTE_W];
    assign hit[g]   = capture && (idx == IDX_W'(g));
    assign merged[g*BYTE_W +: BYTE_W] = hit[g] ? mem_q : asm_q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (start) asm_d = '0;
    else       asm_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      asm_q <= '0;
    else if (asm_en) asm_q <= asm_d;
  end

  assign rdata_d = wr_q ? '0 : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (finish) rdata_q <= rdata_d;
  end

  assign mem_d = (active && wr_q) ? wlane[idx] : '0;
  assign rdata = rdata_q;
  assign wr    = wr_q;

  AST_WR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(wr_q)); // R9

endmodule

// File: rtl/byte_lsu_top.sv
module byte_lsu_top
  import lsu_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mode,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_a,
  output logic [BYTE_W-1:0] mem_d,
  input  logic [BYTE_W-1:0] mem_q,
  output logic              mem_cen,
  output logic              mem_wen,
  output logic              mem_oen
);

  localparam int NLANE = DATA_W / BYTE_W;
  localparam int IDX_W = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic             accept;
  logic             active;
  logic [IDX_W-1:0] idx;
  logic             last_wait;
  logic             finish;
  logic             wr;
  logic [IDX_W-1:0] start_last;

  assign accept     = req_valid && req_mode && !active;
  assign start_last = IDX_W'(size_to_last(req_size));

  lsu_seq #(
    .WAIT_CYC (WAIT_CYC),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_last (start_last),
    .active     (active),
    .idx        (idx),
    .last_wait  (last_wait),
    .finish     (finish),
    .done       (done)
  );

  lsu_addr_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (req_addr),
    .active     (active),
    .idx        (idx),
    .mem_a      (mem_a)
  );

  lsu_byte_path #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .IDX_W  (IDX_W)
  ) u_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_wr    (req_write),
    .start_wdata (req_wdata),
    .active      (active),
    .idx         (idx),
    .last_wait   (last_wait),
    .finish      (finish),
    .mem_q       (mem_q),
    .wr          (wr),
    .mem_d       (mem_d),
    .rdata       (rdata)
  );

  assign busy    = active;
  assign mem_cen = !active;
  assign mem_wen = !(active && wr);
  assign mem_oen = !(active && !wr);

  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cen && mem_wen && mem_oen)); // R5

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cen |-> (mem_wen != mem_oen)); // R5

  AST_ADDR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mem_a != $past(mem_a))) |-> (mem_a == $past(mem_a) + ADDR_W'(1))); // R10

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R7

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata)); // R8

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !$past(req_mode)) |-> !busy); // R2

endmodule

// File: tb/sim_byte_lsu_top.sv
module sim_byte_lsu_top;

  localparam int WAITC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_mode = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [9:0]  req_addr = 10'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        busy, done;
  logic [31:0] rdata;
  logic [9:0]  mem_a;
  logic [7:0]  mem_d, mem_q;
  logic        mem_cen, mem_wen, mem_oen;

  logic [7:0] mem [1024];

  int    n_chk = 0;
  int    n_bad = 0;
  bit    fin = 1'b0;
  string phase = "R1 reset";

  // reference model state
  bit          ref_busy, ref_done, ref_wr;
  int          ref_el, ref_n;
  int          ref_base;
  logic [31:0] ref_wdata, ref_exp, ref_rdata;

  always #4 clk = ~clk;

  byte_lsu_top #(.WAIT_CYC(WAITC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .mem_a(mem_a), .mem_d(mem_d), .mem_q(mem_q), .mem_cen(mem_cen),
    .mem_wen(mem_wen), .mem_oen(mem_oen)
  );

  // external memory model
  assign mem_q = (!mem_cen && !mem_oen) ? mem[mem_a] : 8'h00;
  always @(posedge clk) if (!mem_cen && !mem_wen) mem[mem_a] <= mem_d;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] got=%h expected=%h", tag, phase, got, exp);
    end
  endtask

  // cycle-by-cycle behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_busy = 0; ref_done = 0; ref_wr = 0; ref_el = 0; ref_n = 0;
      ref_base = 0; ref_wdata = '0; ref_exp = '0; ref_rdata = '0;
    end else begin
      ref_done = 0;
      if (ref_busy) begin
        ref_el++;
        if (ref_el == ref_n * WAITC) begin
          ref_busy  = 0;
          ref_done  = 1;
          ref_rdata = ref_wr ? 32'd0 : ref_exp;
        end
      end else if (req_valid && req_mode) begin
        ref_busy  = 1;
        ref_el    = 0;
        ref_wr    = req_write;
        ref_base  = int'(req_addr);
        ref_wdata = req_wdata;
        ref_n     = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4;
        ref_exp   = '0;
        for (int k = 0; k < ref_n; k++)
          ref_exp[8*k +: 8] = mem[(ref_base + k) % 1024];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      int k;
      k = ref_el / WAITC;
      chk("R7 busy", {31'd0, busy}, {31'd0, ref_busy});
      chk("R7 done", {31'd0, done}, {31'd0, ref_done});
      chk("R8 rdata", rdata, ref_rdata);
      if (ref_busy) begin
        chk("R10 mem_a", {22'd0, mem_a}, 32'((ref_base + k) % 1024));
        chk("R5 cen", {31'd0, mem_cen}, 32'd0);
        chk("R5 wen", {31'd0, mem_wen}, {31'd0, !ref_wr});
        chk("R5 oen", {31'd0, mem_oen}, {31'd0, ref_wr});
        chk("R4 mem_d", {24'd0, mem_d}, ref_wr ? {24'd0, ref_wdata[8*k +: 8]} : 32'd0);
      end else begin
        chk("R5 idle cen", {31'd0, mem_cen}, 32'd1);
        chk("R5 idle wen", {31'd0, mem_wen}, 32'd1);
        chk("R5 idle oen", {31'd0, mem_oen}, 32'd1);
        chk("R4 idle mem_d", {24'd0, mem_d}, 32'd0);
      end
    end
  end

  task automatic put_req(input bit md, input bit w, input logic [1:0] sz,
                         input logic [9:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1; req_mode = md; req_write = w; req_size = sz;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (ref_busy || ref_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) & 255);
    repeat (2) @(negedge clk);
    // R1: values held during reset
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 strobes", {29'd0, mem_cen, mem_wen, mem_oen}, 32'd7);
    chk("R1 mem_a", {22'd0, mem_a}, 32'd0);
    chk("R1 mem_d", {24'd0, mem_d}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    phase = "R2 mode clear ignored";
    put_req(0, 1, 2'd2, 10'h050, 32'hDEADBEEF);
    repeat (3) @(negedge clk);
    chk("R2 busy low", {31'd0, busy}, 32'd0);
    chk("R2 mem untouched", {24'd0, mem[10'h050]}, 32'((16'h50 * 37 + 11) & 255));

    phase = "R3 R6 word read";   put_req(1, 0, 2'd2, 10'h010, '0); settle();
    phase = "R3 halfword read";  put_req(1, 0, 2'd1, 10'h021, '0); settle();
    phase = "R3 byte read";      put_req(1, 0, 2'd0, 10'h003, '0); settle();
    phase = "R3 size3 word read"; put_req(1, 0, 2'd3, 10'h100, '0); settle();
    phase = "R4 word write";     put_req(1, 1, 2'd2, 10'h040, 32'hA1B2C3D4); settle();
    phase = "R4 R8 readback";    put_req(1, 0, 2'd2, 10'h040, '0); settle();
    chk("R8 readback word", rdata, 32'hA1B2C3D4);
    phase = "R4 halfword write"; put_req(1, 1, 2'd1, 10'h081, 32'h11223344); settle();
    phase = "R8 half readback";  put_req(1, 0, 2'd2, 10'h080, '0); settle();
    phase = "R4 byte write";     put_req(1, 1, 2'd0, 10'h0C2, 32'h000000E7); settle();
    chk("R4 byte landed", {24'd0, mem[10'h0C2]}, 32'hE7);
    chk("R4 neighbour kept", {24'd0, mem[10'h0C3]}, 32'((16'hC3 * 37 + 11) & 255));
    phase = "R10 wrap read";     put_req(1, 0, 2'd2, 10'd1022, '0); settle();
    phase = "R10 wrap write";    put_req(1, 1, 2'd2, 10'd1023, 32'h55667788); settle();
    chk("R10 wrapped byte", {24'd0, mem[0]}, 32'h77);
    chk("R10 top byte", {24'd0, mem[1023]}, 32'h88);

    phase = "R9 request during busy";
    put_req(1, 0, 2'd2, 10'h200, '0);
    repeat (3) begin
      @(negedge clk);
      req_valid = 1; req_mode = 1; req_write = 1; req_size = 2'd0;
      req_addr = 10'h300; req_wdata = 32'hFF;
    end
    @(negedge clk); req_valid = 0;
    settle();
    chk("R9 no stray write", {24'd0, mem[10'h300]}, 32'((16'h300 * 37 + 11) & 255));

    phase = "R11 back to back";
    @(negedge clk);
    req_valid = 1; req_mode = 1; req_write = 0; req_size = 2'd1; req_addr = 10'h120;
    repeat (2 * 2 * WAITC + 4) @(negedge clk);
    req_valid = 0;
    settle();

    fin = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog [%s] got=timeout expected=finish", phase);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule